// File: doc/BRIEF.md
# Banked CPU Register File

This block is the register file of a small 8-bit processor. It holds sixteen 8-bit entries: six general registers, a stack pointer, an instruction pointer, four alternate general registers that can be swapped in by a bank flag, and four segment registers (code, data, extra and stack). Instructions name registers with 3-bit numbers. The block turns each number into a 4-bit physical index. Only the numbers 0 to 3 follow the bank flag. The numbers 4 to 7 always reach r4, r5, SP and IP.

Each access port has its own segment selector. When it is set, the two low bits of the register number pick one of the four segment registers, so segment registers never collide with the banked numbering. There are two combinational read ports and one write port. The bank flag has separate set-to-0 and set-to-1 commands. The four segment registers are also driven straight out, so address generation can use them without taking a read port. Reset is synchronous, is active high, and loads a fixed starting state.

Top module: `cpu_regbank`

## Requirements
- R1: The cycle after reset is sampled high, the bank flag reads 0 and the segment outputs read CS=1, DS=0, ES=0 and SS=2. At that point every general register in both banks, SP and IP read 0.
- R2: With the segment selector low and register number 4 to 7, a read returns physical entry 4 to 7 (r4, r5, SP, IP) whatever the bank flag is.
- R3: With the segment selector low and register number 0 to 3, a read returns physical entry number+8 when the bank flag is 1, and physical entry number when it is 0.
- R4: With the segment selector high, number bits [1:0] pick 00=CS, 01=DS, 10=ES, 11=SS (physical entries 12 to 15). Bit 2 of the number is ignored.
- R5: A write enabled at a clock edge is stored at that edge and appears on the reads from the next cycle. A read of the entry being written, in the same cycle, returns the old value.
- R6: When only the set-to-1 command is high at an edge, the bank flag becomes 1. When only set-to-0 is high, it becomes 0. When both are high, the flag does not change. A write in the same cycle as a bank command is mapped with the old flag.
- R7: When reset is high, it overrides any write and any bank command in the same cycle.
- R8: The four segment outputs always show the current contents of CS, DS, ES and SS.
- R9: A write changes only the single addressed entry. All other entries, including the segment outputs, stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank0_cmd | input | 1 | Select bank 0 at the next edge |
| bank1_cmd | input | 1 | Select bank 1 at the next edge |
| ra_sel | input | 3 | Read port A register number |
| ra_seg | input | 1 | Read port A segment selector |
| ra_data | output | 8 | Read port A data |
| rb_sel | input | 3 | Read port B register number |
| rb_seg | input | 1 | Read port B segment selector |
| rb_data | output | 8 | Read port B data |
| we | input | 1 | Write enable |
| we_seg | input | 1 | Write port segment selector |
| we_sel | input | 3 | Write register number |
| we_data | input | 8 | Write data |
| bank | output | 1 | Current bank flag |
| cs_q | output | 8 | Code segment register |
| ds_q | output | 8 | Data segment register |
| es_q | output | 8 | Extra segment register |
| ss_q | output | 8 | Stack segment register |

## Verification
Read data is due in the same cycle as its selects, because the read path has no register. Writes, bank commands and reset each go through one register, so their results are due one cycle after the edge that samples them. The bench drives inputs just after a falling edge and compares every output a moment later, which lets it see combinational reads in the same half cycle. It then updates its model at the rising edge, so stored effects are compared in the following cycle. Cycles where a read hits the entry being written are compared against the model's old value. This confirms that write data does not pass straight through to the read port.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W   = 8;
  localparam int ARCH_W   = 3;
  localparam int PHYS_W   = ARCH_W + 1;
  localparam int ENTRIES  = 1 << PHYS_W;
  localparam int SEG_W    = 2;
  localparam int SEG_BASE = ENTRIES - (1 << SEG_W);
  localparam int CS_IDX   = SEG_BASE + 0;
  localparam int DS_IDX   = SEG_BASE + 1;
  localparam int ES_IDX   = SEG_BASE + 2;
  localparam int SS_IDX   = SEG_BASE + 3;
  localparam int CS_INIT  = 1;
  localparam int SS_INIT  = 2;

  typedef logic [PHYS_W-1:0] phys_t;
  typedef logic [ARCH_W-1:0] arch_t;
  typedef logic [DATA_W-1:0] word_t;

  // Architectural number plus selectors -> physical slot.
  function automatic phys_t map_phys(arch_t num, logic seg, logic bank_bit);
    phys_t p;
    if (seg) begin
      p = phys_t'(SEG_BASE) | phys_t'(num[SEG_W-1:0]);
    end else if (num[ARCH_W-1]) begin
      p = {1'b0, num};
    end else begin
      p = {bank_bit, num};
    end
    return p;
  endfunction

  // Value each slot takes at reset.
  function automatic word_t reset_word(int idx);
    word_t w;
    if (idx == CS_IDX)      w = word_t'(CS_INIT);
    else if (idx == SS_IDX) w = word_t'(SS_INIT);
    else                    w = '0;
    return w;
  endfunction
endpackage

// File: rtl/regbank_map.sv
module regbank_map
  import regbank_pkg::*;
(
  input  arch_t num,
  input  logic  seg,
  input  logic  bank_bit,
  output phys_t phys
);
  always_comb phys = map_phys(num, seg, bank_bit);
endmodule

// File: rtl/regbank_flag.sv
module regbank_flag (
  input  logic clk,
  input  logic rst,
  input  logic set0,
  input  logic set1,
  output logic bank_q
);
  logic bank_d;

  always_comb begin
    bank_d = bank_q;
    if (set1 && !set0)      bank_d = 1'b1;
    else if (set0 && !set1) bank_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) bank_q <= 1'b0;
    else     bank_q <= bank_d;
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int N     = ENTRIES,
  localparam int IW   = $clog2(N)
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [W-1:0]         wr_data,
  input  logic [IW-1:0]        rd_a_idx,
  input  logic [IW-1:0]        rd_b_idx,
  output logic [W-1:0]         rd_a,
  output logic [W-1:0]         rd_b,
  output logic [N-1:0]         strobe,
  output logic [N-1:0][W-1:0]  q
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam logic [W-1:0] INIT = W'(reset_word(i));
    assign strobe[i] = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk) begin
      if (rst)            q[i] <= INIT;
      else if (strobe[i]) q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_a = q[rd_a_idx];
    rd_b = q[rd_b_idx];
  end
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bank0_cmd,
  input  logic              bank1_cmd,
  input  logic [ARCH_W-1:0] ra_sel,
  input  logic              ra_seg,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ARCH_W-1:0] rb_sel,
  input  logic              rb_seg,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic              we_seg,
  input  logic [ARCH_W-1:0] we_sel,
  input  logic [DATA_W-1:0] we_data,
  output logic              bank,
  output logic [DATA_W-1:0] cs_q,
  output logic [DATA_W-1:0] ds_q,
  output logic [DATA_W-1:0] es_q,
  output logic [DATA_W-1:0] ss_q
);
  localparam int PORTS = 3;
  localparam int PA = 0, PB = 1, PW = 2;

  arch_t nums [PORTS];
  logic  segs [PORTS];
  phys_t phys [PORTS];

  // Named internal events for the checker.
  phys_t                    phys_a, phys_b, phys_w;
  logic [ENTRIES-1:0]       wr_strobe;
  logic [ENTRIES-1:0][DATA_W-1:0] regs_q;

  assign nums[PA] = ra_sel; assign segs[PA] = ra_seg;
  assign nums[PB] = rb_sel; assign segs[PB] = rb_seg;
  assign nums[PW] = we_sel; assign segs[PW] = we_seg;

  regbank_flag u_flag (
    .clk(clk), .rst(rst), .set0(bank0_cmd), .set1(bank1_cmd), .bank_q(bank)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    regbank_map u_map (
      .num(nums[p]), .seg(segs[p]), .bank_bit(bank), .phys(phys[p])
    );
  end

  assign phys_a = phys[PA];
  assign phys_b = phys[PB];
  assign phys_w = phys[PW];

  regbank_store #(.W(DATA_W), .N(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .wr_en(we), .wr_idx(phys_w), .wr_data(we_data),
    .rd_a_idx(phys_a), .rd_b_idx(phys_b), .rd_a(ra_data), .rd_b(rb_data),
    .strobe(wr_strobe), .q(regs_q)
  );

  assign cs_q = regs_q[CS_IDX];
  assign ds_q = regs_q[DS_IDX];
  assign es_q = regs_q[ES_IDX];
  assign ss_q = regs_q[SS_IDX];
endmodule

// File: rtl/cpu_regbank_checker.sv
module cpu_regbank_checker
  import regbank_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bank0_cmd,
  input logic              bank1_cmd,
  input logic [ARCH_W-1:0] ra_sel,
  input logic              ra_seg,
  input logic              we,
  input logic              we_seg,
  input logic [ARCH_W-1:0] we_sel,
  input logic [DATA_W-1:0] we_data,
  input logic              bank,
  input logic [DATA_W-1:0] cs_q,
  input logic [DATA_W-1:0] ds_q,
  input logic [DATA_W-1:0] es_q,
  input logic [DATA_W-1:0] ss_q,
  input logic [PHYS_W-1:0] phys_a,
  input logic [ENTRIES-1:0] wr_strobe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!bank && cs_q == 8'd1 && ss_q == 8'd2 && ds_q == 8'd0 && es_q == 8'd0));

  assert_fixed_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (!ra_seg && ra_sel[2]) |-> (phys_a[3] == 1'b0));

  assert_banked_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (!ra_seg && !ra_sel[2]) |-> (phys_a[3] == bank));

  assert_bank_one_R6: assert property (@(posedge clk) disable iff (rst)
    (bank1_cmd && !bank0_cmd) |=> bank);

  assert_bank_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bank0_cmd && !bank1_cmd) |=> !bank);

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (bank0_cmd == bank1_cmd) |=> $stable(bank));

  assert_cs_write_R8: assert property (@(posedge clk) disable iff (rst)
    (we && we_seg && we_sel[1:0] == 2'b00) |=> (cs_q == $past(we_data)));

  assert_one_entry_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_strobe));

  assert_segs_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (we && !we_seg) |=> ($stable(cs_q) && $stable(ds_q) && $stable(es_q) && $stable(ss_q)));
endmodule

bind cpu_regbank cpu_regbank_checker chk_i (
  .clk(clk), .rst(rst), .bank0_cmd(bank0_cmd), .bank1_cmd(bank1_cmd),
  .ra_sel(ra_sel), .ra_seg(ra_seg), .we(we), .we_seg(we_seg), .we_sel(we_sel),
  .we_data(we_data), .bank(bank), .cs_q(cs_q), .ds_q(ds_q), .es_q(es_q),
  .ss_q(ss_q), .phys_a(phys_a), .wr_strobe(wr_strobe)
);

// File: tb/cpu_regbank_tb_top.sv
module cpu_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst, bank0_cmd, bank1_cmd, ra_seg, rb_seg, we, we_seg, bnk;
  logic [2:0] ra_sel, rb_sel, we_sel;
  logic [7:0] we_data, ra_data, rb_data, cs_q, ds_q, es_q, ss_q;

  int compared = 0, mismatched = 0;
  int mreg [16];
  int mbank;
  bit after_rst;
  string force_tag = "";
  bit done = 0;

  always #10 clk = ~clk;

  cpu_regbank dut_i (
    .clk(clk), .rst(rst), .bank0_cmd(bank0_cmd), .bank1_cmd(bank1_cmd),
    .ra_sel(ra_sel), .ra_seg(ra_seg), .ra_data(ra_data),
    .rb_sel(rb_sel), .rb_seg(rb_seg), .rb_data(rb_data),
    .we(we), .we_seg(we_seg), .we_sel(we_sel), .we_data(we_data),
    .bank(bnk), .cs_q(cs_q), .ds_q(ds_q), .es_q(es_q), .ss_q(ss_q)
  );

  // Requirement-level slot rule, written from the requirement text.
  function automatic int slot(int num, int seg, int bk);
    if (seg != 0) return 12 + (num % 4);
    if (num >= 4) return num;
    return (bk != 0) ? num + 8 : num;
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string read_tag(int num, int seg);
    if (force_tag != "") return force_tag;
    if (after_rst) return "R1";
    if (we && slot(we_sel, we_seg, mbank) == slot(num, seg, mbank)) return "R5";
    if (seg != 0) return "R4";
    if (num >= 4) return "R2";
    return "R3";
  endfunction

  task automatic compare_all();
    string st;
    st = (force_tag != "") ? force_tag : (after_rst ? "R1" : "R8");
    chk((force_tag != "") ? force_tag : (after_rst ? "R1" : "R6"), bnk, mbank, "bank");
    chk(st, cs_q, mreg[12], "cs");
    chk(st, ds_q, mreg[13], "ds");
    chk(st, es_q, mreg[14], "es");
    chk(st, ss_q, mreg[15], "ss");
    chk(read_tag(ra_sel, ra_seg), ra_data, mreg[slot(ra_sel, ra_seg, mbank)], "port A");
    chk(read_tag(rb_sel, rb_seg), rb_data, mreg[slot(rb_sel, rb_seg, mbank)], "port B");
  endtask

  task automatic model_edge();
    if (rst) begin
      foreach (mreg[i]) mreg[i] = 0;
      mreg[12] = 1; mreg[15] = 2; mbank = 0; after_rst = 1;
    end else begin
      after_rst = 0;
      if (we) mreg[slot(we_sel, we_seg, mbank)] = we_data;
      if (bank1_cmd && !bank0_cmd) mbank = 1;
      else if (bank0_cmd && !bank1_cmd) mbank = 0;
    end
  endtask

  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    rst = 0; bank0_cmd = 0; bank1_cmd = 0; we = 0; we_seg = 0;
    we_sel = 0; we_data = 0; ra_sel = 0; ra_seg = 0; rb_sel = 0; rb_seg = 0;
  endtask

  task automatic wr(int seg, int num, int data);
    we = 1; we_seg = 1'(seg); we_sel = 3'(num); we_data = 8'(data);
  endtask

  initial begin
    foreach (mreg[i]) mreg[i] = 0;
    mbank = 0; after_rst = 0;
    idle();
    @(negedge clk);
    // R7: reset with a write and a bank command pending.
    rst = 1; wr(1, 0, 8'h77); bank1_cmd = 1;
    @(posedge clk); model_edge(); @(negedge clk);
    idle(); rst = 1;
    @(posedge clk); model_edge(); @(negedge clk);
    idle(); force_tag = "R7"; we = 1; we_sel = 3'd2; we_data = 8'h10; rst = 1;
    @(posedge clk); model_edge(); @(negedge clk);
    idle(); ra_sel = 3'd2; rb_seg = 1; rb_sel = 3'd0;
    step();
    force_tag = "";
    // R1: reset state of all slots.
    for (int n = 0; n < 8; n++) begin
      ra_sel = 3'(n); rb_sel = 3'(n); rb_seg = 1; force_tag = "R1"; step();
    end
    force_tag = "";
    // R2/R3: fill bank 0 and fixed slots, then bank 1.
    for (int n = 0; n < 8; n++) begin wr(0, n, 8'h20 + n); step(); end
    idle(); bank1_cmd = 1; step();
    idle();
    for (int n = 0; n < 4; n++) begin wr(0, n, 8'h40 + n); step(); end
    idle();
    for (int n = 0; n < 8; n++) begin ra_sel = 3'(n); rb_sel = 3'(7 - n); step(); end
    // R6: both commands together hold; write with bank change uses old bank.
    idle(); bank0_cmd = 1; bank1_cmd = 1; step();
    idle(); bank0_cmd = 1; wr(0, 1, 8'h99); ra_sel = 3'd1; step();
    idle(); ra_sel = 3'd1; force_tag = "R6"; step(); force_tag = "";
    // R4: segment writes with bit 2 set, ignored.
    for (int n = 0; n < 4; n++) begin wr(1, n + 4, 8'hA0 + n); step(); end
    idle();
    for (int n = 0; n < 4; n++) begin ra_seg = 1; ra_sel = 3'(n); step(); end
    // R5: same-cycle read of written entry sees old value.
    idle(); wr(0, 6, 8'h5C); ra_sel = 3'd6; step();
    idle(); ra_sel = 3'd6; step();
    // R9: single write, other slots unchanged.
    idle(); wr(0, 3, 8'hEE); step();
    idle(); force_tag = "R9";
    for (int n = 0; n < 8; n++) begin ra_sel = 3'(n); rb_seg = 1; rb_sel = 3'(n); step(); end
    force_tag = "";
    // Random traffic.
    for (int k = 0; k < 3000; k++) begin
      rst = ($urandom_range(0, 63) == 0);
      bank0_cmd = 1'($urandom_range(0, 3) == 0);
      bank1_cmd = 1'($urandom_range(0, 3) == 0);
      we = 1'($urandom_range(0, 1)); we_seg = 1'($urandom_range(0, 3) == 0);
      we_sel = 3'($urandom_range(0, 7)); we_data = 8'($urandom_range(0, 255));
      ra_sel = 3'($urandom_range(0, 7)); ra_seg = 1'($urandom_range(0, 3) == 0);
      rb_sel = 3'($urandom_range(0, 7)); rb_seg = 1'($urandom_range(0, 3) == 0);
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule